// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Block

This block holds the host-visible control and status registers for two bus-master DMA channels of a disk controller. One base address opens a 16-byte I/O window. Channel 0 occupies the first 8 bytes and channel 1 the next 8. In each channel, the first dword holds a command byte and a status byte, and the second dword holds a 32-bit pointer to the descriptor table. The host reaches the registers over a simple I/O bus that carries a dword address, byte enables, write data, read and write strobes, and a registered read-data return.

The descriptor-walking engine sits beside this block. The block sends the engine a start pulse and a direction bit for each channel. The engine reports back with per-channel event inputs: transfer begin, transfer end, error and interrupt.

Each channel contains a two-state activity machine with these states and transitions:
- `CH_IDLE`: no transfer in progress. The `go` transition moves to `CH_ACTIVE` when `eng_begin` is high.
- `CH_ACTIVE`: a transfer is in progress. The `finish` transition moves back to `CH_IDLE` when `eng_end` is high.

Reset forces both machines to `CH_IDLE`. Status bit 0 reads 1 exactly while the machine is in `CH_ACTIVE`.

Top module: `bm_dma_regs`

## Requirements
- R1: Channel c starts at byte address BASE_ADDR + 8*c.
  - In the channel's first dword, lane 0 (bits 7:0) is the command byte and lane 2 (bits 23:16) is the status byte. Lanes 1 and 3 read 0xFF and ignore writes.
  - The channel's second dword is the descriptor pointer.
- R2: Read latency and out-of-window accesses.
  - A read captured on a clock edge places its dword on `io_rdata` after that edge, and `io_rdata` holds until the next read.
  - A read outside the 16-byte window returns 0xFFFFFFFF.
  - A write outside the window changes nothing.
- R3: The command byte has two read/write bits: bit 0 (start/stop) and bit 3 (direction). Its other bits read 0. A write to the status lane leaves the command byte unchanged.
- R4: A command write whose bit 0 is 1 raises `eng_start[c]` for exactly the one cycle after the write edge.
  - A command write whose bit 0 is 0 raises no pulse.
  - `eng_dir[c]` follows command bit 3.
- R5: A status write loads status bits 6 and 5 from the written data.
- R6: Status bit 1 (error) and bit 2 (interrupt) clear when the written data has a 1 in that position and keep their value when it has a 0.
- R7: `eng_err[c]` sets status bit 1 and `eng_irq[c]` sets status bit 2. When a hardware set and a host clear hit the same bit in the same cycle, the bit ends up set.
- R8: Status bit 0 follows the activity machine, is set by `eng_begin` and cleared by `eng_end`, and no host write changes it. Status bits 7, 4 and 3 always read 0.
- R9: The pointer accepts any mix of byte lanes, so 8-, 16- and 32-bit writes all work. Its bits 1:0 always read 0.
- R10: After reset, every register, both activity machines, `io_rdata` and `eng_start` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W-2 | Dword address (byte-address bits ADDR_W-1..2) |
| io_be | input | 4 | Byte-lane enables for writes |
| io_wdata | input | 32 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 32 | Registered read data |
| eng_begin | input | NUM_CH | Engine reports transfer started, per channel |
| eng_end | input | NUM_CH | Engine reports transfer finished, per channel |
| eng_err | input | NUM_CH | Engine error event, per channel |
| eng_irq | input | NUM_CH | Engine interrupt event, per channel |
| eng_start | output | NUM_CH | One-cycle start pulse, per channel |
| eng_dir | output | NUM_CH | Transfer direction from command bit 3, per channel |

## Verification
The embedded assertions check several rules on every cycle:
- hardware sets dominate and host clears work on the error and interrupt bits;
- host writes leave the activity bit alone;
- the command byte stays stable without a command write;
- start pulses follow command writes;
- out-of-window reads return all ones and the read data holds between reads.

The bench scenarios are what show the address map and the per-lane pointer merging. They also show that each channel is isolated from the other, that lanes 1 and 3 ignore writes, and that reset takes effect in the middle of a transfer. Each of these needs a sequence of accesses followed by read-back.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;

    // Per-channel layout inside the window
    localparam int CH_STRIDE_BYTES = 8;
    localparam int DW_PER_CH       = CH_STRIDE_BYTES / 4;

    // Byte lanes within the control dword
    localparam int LANE_CMD  = 0;
    localparam int LANE_STAT = 2;

    // Command bit positions
    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;

    // Status bit positions
    localparam int ST_ACT_BIT = 0;
    localparam int ST_ERR_BIT = 1;
    localparam int ST_IRQ_BIT = 2;
    localparam int ST_CFG_LO  = 5;
    localparam int ST_CFG_HI  = 6;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic {
        CH_IDLE   = 1'b0,
        CH_ACTIVE = 1'b1
    } ch_state_e;

    // Pointer lane mask: keeps the pointer dword aligned
    function automatic logic [7:0] ptr_lane_mask(input int lane);
        return (lane == 0) ? 8'hFC : 8'hFF;
    endfunction

endpackage

// File: rtl/bm_dma_decode.sv
module bm_dma_decode #(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_CH    = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0C00,
    localparam int               DA_W      = ADDR_W - 2,
    localparam int               CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [DA_W-1:0] addr,
    output logic            hit,
    output logic [CH_W-1:0] ch_sel,
    output logic            dw_sel
);
    localparam logic [DA_W-1:0] BASE_DW = BASE_ADDR[ADDR_W-1:2];

    logic [DA_W:0]   diff;
    logic [DA_W-1:0] off;
    logic            borrow;

    always_comb begin
        diff   = {1'b0, addr} - {1'b0, BASE_DW};
        borrow = diff[DA_W];
        off    = diff[DA_W-1:0];
        hit    = !borrow && (off[DA_W-1:1+CH_W] == '0);
        ch_sel = off[1 +: CH_W];
        dw_sel = off[0];
    end

endmodule

// File: rtl/bm_dma_chan.sv
module bm_dma_chan
    import bm_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic        stat_we,
    input  logic [3:0]  ptr_be,
    input  logic [31:0] wdata,
    input  logic        xfer_begin,
    input  logic        xfer_end,
    input  logic        hw_err,
    input  logic        hw_irq,
    output logic [7:0]  cmd,
    output logic [7:0]  stat,
    output logic [31:0] ptr,
    output logic        start_pulse
);
    localparam int STAT_LSB = 8 * LANE_STAT;
    localparam int CMD_LSB  = 8 * LANE_CMD;

    ch_state_e   state_q, state_d;
    logic        run_q, dir_q, err_q, irq_q;
    logic [1:0]  cfg_q;
    logic [31:0] ptr_q;
    logic        err_clr, irq_clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: go, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:   if (xfer_begin) state_d = CH_ACTIVE;
            CH_ACTIVE: if (xfer_end)   state_d = CH_IDLE;
        endcase
    end

    assign err_clr = stat_we & wdata[STAT_LSB + ST_ERR_BIT];
    assign irq_clr = stat_we & wdata[STAT_LSB + ST_IRQ_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            dir_q       <= 1'b0;
            cfg_q       <= 2'b00;
            err_q       <= 1'b0;
            irq_q       <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            if (cmd_we) begin
                run_q <= wdata[CMD_LSB + CMD_RUN_BIT];
                dir_q <= wdata[CMD_LSB + CMD_DIR_BIT];
            end
            start_pulse <= cmd_we & wdata[CMD_LSB + CMD_RUN_BIT];
            if (stat_we)
                cfg_q <= wdata[STAT_LSB + ST_CFG_HI : STAT_LSB + ST_CFG_LO];
            err_q <= hw_err | (err_q & ~err_clr);
            irq_q <= hw_irq | (irq_q & ~irq_clr);
        end
    end

    for (genvar b = 0; b < 4; b++) begin : g_ptr_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q[8*b +: 8] <= 8'h00;
            else if (ptr_be[b])
                ptr_q[8*b +: 8] <= wdata[8*b +: 8] & ptr_lane_mask(b);
        end
    end

    // Outputs
    always_comb begin
        cmd                 = 8'h00;
        cmd[CMD_RUN_BIT]    = run_q;
        cmd[CMD_DIR_BIT]    = dir_q;
        stat                = 8'h00;
        stat[ST_ACT_BIT]    = (state_q == CH_ACTIVE);
        stat[ST_ERR_BIT]    = err_q;
        stat[ST_IRQ_BIT]    = irq_q;
        stat[ST_CFG_HI:ST_CFG_LO] = cfg_q;
        ptr                 = ptr_q;
    end

    // Assertions
    a_r3_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd));
    a_r4_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wdata[CMD_LSB + CMD_RUN_BIT]) |=> start_pulse);
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !(cmd_we && wdata[CMD_LSB + CMD_RUN_BIT])) |=> !start_pulse);
    a_r5_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> (stat[ST_CFG_HI:ST_CFG_LO] == $past(wdata[STAT_LSB + ST_CFG_HI : STAT_LSB + ST_CFG_LO])));
    a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && wdata[STAT_LSB + ST_ERR_BIT] && !hw_err) |=> !stat[ST_ERR_BIT]);
    a_r6_irq_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ST_IRQ_BIT] && !(stat_we && wdata[STAT_LSB + ST_IRQ_BIT])) |=> stat[ST_IRQ_BIT]);
    a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |=> stat[ST_ERR_BIT]);
    a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq |=> stat[ST_IRQ_BIT]);
    a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_begin && !xfer_end) |=> $stable(stat[ST_ACT_BIT]));

endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
    import bm_dma_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_CH    = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0C00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-3:0]   io_addr,
    input  logic [3:0]          io_be,
    input  logic [31:0]         io_wdata,
    input  logic                io_wr,
    input  logic                io_rd,
    output logic [31:0]         io_rdata,
    input  logic [NUM_CH-1:0]   eng_begin,
    input  logic [NUM_CH-1:0]   eng_end,
    input  logic [NUM_CH-1:0]   eng_err,
    input  logic [NUM_CH-1:0]   eng_irq,
    output logic [NUM_CH-1:0]   eng_start,
    output logic [NUM_CH-1:0]   eng_dir
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic            hit, dw_sel;
    logic [CH_W-1:0] ch_sel;

    logic [7:0]  cmd_a  [NUM_CH];
    logic [7:0]  stat_a [NUM_CH];
    logic [31:0] ptr_a  [NUM_CH];

    bm_dma_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CH    (NUM_CH),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr   (io_addr),
        .hit    (hit),
        .ch_sel (ch_sel),
        .dw_sel (dw_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic       sel_ctl, sel_ptr;
        logic [3:0] ptr_be;

        assign sel_ctl = io_wr && hit && (ch_sel == CH_W'(c)) && !dw_sel;
        assign sel_ptr = io_wr && hit && (ch_sel == CH_W'(c)) &&  dw_sel;
        assign ptr_be  = {4{sel_ptr}} & io_be;

        bm_dma_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_we      (sel_ctl && io_be[LANE_CMD]),
            .stat_we     (sel_ctl && io_be[LANE_STAT]),
            .ptr_be      (ptr_be),
            .wdata       (io_wdata),
            .xfer_begin  (eng_begin[c]),
            .xfer_end    (eng_end[c]),
            .hw_err      (eng_err[c]),
            .hw_irq      (eng_irq[c]),
            .cmd         (cmd_a[c]),
            .stat        (stat_a[c]),
            .ptr         (ptr_a[c]),
            .start_pulse (eng_start[c])
        );

        assign eng_dir[c] = cmd_a[c][CMD_DIR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            io_rdata <= 32'h0;
        else if (io_rd) begin
            if (!hit)
                io_rdata <= {4{FILL_BYTE}};
            else if (dw_sel)
                io_rdata <= ptr_a[ch_sel];
            else
                io_rdata <= {FILL_BYTE, stat_a[ch_sel], FILL_BYTE, cmd_a[ch_sel]};
        end
    end

    a_r2_outside_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !hit) |=> (io_rdata == 32'hFFFF_FFFF));
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

endmodule

// File: tb/bm_dma_regs_test.sv
`timescale 1ns/1ps
module bm_dma_regs_test;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [31:0] io_rdata;
    logic [NCH-1:0] eng_begin = '0, eng_end = '0, eng_err = '0, eng_irq = '0;
    logic [NCH-1:0] eng_start, eng_dir;

    int total = 0;
    int bad = 0;
    logic rd_q = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    bm_dma_regs uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_be(io_be),
        .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .eng_begin(eng_begin), .eng_end(eng_end), .eng_err(eng_err),
        .eng_irq(eng_irq), .eng_start(eng_start), .eng_dir(eng_dir)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one access per cycle, entered and left at a falling edge
    task automatic wr(input logic [15:0] baddr, input logic [3:0] be, input logic [31:0] d);
        io_addr = baddr[15:2]; io_be = be; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_be = '0;
    endtask

    task automatic rd(input logic [15:0] baddr, input logic [31:0] exp, input string tag);
        io_addr = baddr[15:2]; io_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // Monitor: compare one cycle after each captured read
    always @(posedge clk) rd_q <= io_rd;
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected read result actual=%h expected=none", io_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, io_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 rdata in reset", io_rdata, 32'h0);
        check("R10 start in reset", {30'b0, eng_start}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        rd(16'h0C00, 32'hFF00FF00, "R10 R1 ch0 ctl after reset");
        rd(16'h0C04, 32'h0,        "R10 ch0 ptr after reset");
        rd(16'h0C08, 32'hFF00FF00, "R1 ch1 ctl after reset");

        // R3/R4: command write, bits 0 and 3 kept, start pulse
        wr(16'h0C00, 4'b0001, 32'h0000_00FF);
        check("R4 start pulse ch0", {30'b0, eng_start}, 32'h1);
        check("R4 dir ch0", {30'b0, eng_dir}, 32'h1);
        @(negedge clk);
        check("R4 start single cycle", {30'b0, eng_start}, 32'h0);
        rd(16'h0C00, 32'hFF00FF09, "R3 cmd masked");

        // R5/R8: status write of all ones
        wr(16'h0C00, 4'b0100, 32'h00FF_0000);
        check("R4 no pulse on status write", {30'b0, eng_start}, 32'h0);
        rd(16'h0C00, 32'hFF60FF09, "R5 R8 R3 status all ones");

        // R7/R8: hardware events
        eng_err[0] = 1'b1; eng_irq[0] = 1'b1; eng_begin[0] = 1'b1;
        @(negedge clk);
        eng_err[0] = 1'b0; eng_irq[0] = 1'b0; eng_begin[0] = 1'b0;
        rd(16'h0C00, 32'hFF67FF09, "R7 R8 hardware set");

        // R6: clear only bit 1
        wr(16'h0C00, 4'b0100, 32'h0002_0000);
        rd(16'h0C00, 32'hFF05FF09, "R6 clear error keep irq");

        // R7: hardware set beats host clear
        eng_irq[0] = 1'b1;
        wr(16'h0C00, 4'b0100, 32'h0004_0000);
        eng_irq[0] = 1'b0;
        rd(16'h0C00, 32'hFF05FF09, "R7 set wins");
        wr(16'h0C00, 4'b0100, 32'h0004_0000);
        rd(16'h0C00, 32'hFF01FF09, "R6 clear irq");

        // R8: host write cannot drop the active bit
        wr(16'h0C00, 4'b0100, 32'h0001_0000);
        rd(16'h0C00, 32'hFF01FF09, "R8 active unaffected by write");
        eng_end[0] = 1'b1;
        @(negedge clk);
        eng_end[0] = 1'b0;
        rd(16'h0C00, 32'hFF00FF09, "R8 finish clears active");

        // R9: pointer lanes and alignment
        wr(16'h0C04, 4'b1111, 32'h1234_5677);
        rd(16'h0C04, 32'h1234_5674, "R9 full word aligned");
        wr(16'h0C04, 4'b0010, 32'h0000_AB00);
        rd(16'h0C04, 32'h1234_AB74, "R9 byte lane 1");
        wr(16'h0C04, 4'b1100, 32'hCDEF_0000);
        rd(16'h0C04, 32'hCDEF_AB74, "R9 upper half");
        wr(16'h0C04, 4'b0001, 32'h0000_0003);
        rd(16'h0C04, 32'hCDEF_AB00, "R9 low byte aligned");

        // R1: channel 1 independent
        rd(16'h0C08, 32'hFF00FF00, "R1 ch1 untouched");
        rd(16'h0C0C, 32'h0,        "R1 ch1 ptr untouched");
        wr(16'h0C08, 4'b0001, 32'h0000_0008);
        check("R4 no pulse when bit0 clear", {30'b0, eng_start}, 32'h0);
        check("R4 dir ch1", {30'b0, eng_dir}, 32'h3);
        wr(16'h0C0C, 4'b1111, 32'h8000_0010);
        rd(16'h0C08, 32'hFF00FF08, "R1 ch1 cmd");
        rd(16'h0C0C, 32'h8000_0010, "R1 ch1 ptr");
        rd(16'h0C04, 32'hCDEF_AB00, "R1 ch0 ptr isolated");

        // R1: lanes 1 and 3 ignore writes
        wr(16'h0C00, 4'b1010, 32'hFFFF_FFFF);
        rd(16'h0C00, 32'hFF00FF09, "R1 filler lanes ignore writes");

        // R2: outside the window
        wr(16'h0C10, 4'b1111, 32'h0);
        wr(16'h0BFC, 4'b1111, 32'h0);
        rd(16'h0C10, 32'hFFFF_FFFF, "R2 read above window");
        rd(16'h0BFC, 32'hFFFF_FFFF, "R2 read below window");
        rd(16'h0C00, 32'hFF00FF09, "R2 write outside no effect");
        rd(16'h0C0C, 32'h8000_0010, "R2 ch1 ptr after outside write");

        // R2: read data holds without a read
        wr(16'h0C0C, 4'b1111, 32'h0000_0040);
        @(negedge clk);
        check("R2 rdata holds", io_rdata, 32'h8000_0010);

        // R10: reset during an active transfer
        eng_begin[1] = 1'b1;
        @(negedge clk);
        eng_begin[1] = 1'b0;
        rd(16'h0C08, 32'hFF01FF08, "R8 ch1 active");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(16'h0C08, 32'hFF00FF00, "R10 ch1 after reset");
        rd(16'h0C04, 32'h0,        "R10 ch0 ptr after reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R2 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule